// File: doc/BRIEF.md
# Keyed Decimal Digit Entry Register

This block builds a three-digit decimal number from presses on a ten-key pad and holds it as packed BCD in a 12-bit register. Each key is an active-low line, and a separate active-low clear key empties the register. When a key press is seen, the block encodes the highest-numbered key that is down into BCD and starts a pulse of fixed length. When the pulse ends, a three-bit one-hot slot pointer takes one step. The slot that the pointer has just entered receives the digit. The first digit after a clear goes into the most significant nibble.

Everything runs on one clock with a synchronous active-high reset. The key and clear inputs each pass through a two-flop synchronizer. The pulse length is the `PULSE_CYCLES` parameter. Its default is 20 ms at 250 MHz, and a testbench can set it much shorter. A held key gives exactly one step. The next step needs every key to be released first. The stored value and the pointer are outputs, so a display decoder or an arithmetic unit can use them.

Top module: `digit_entry_reg`

## Requirements
- R1: When the synchronized clear key is low, the next clock sets `digit_value` to 0 and `slot_ptr` to 3'b001. The pointer bits are `slot_ptr[2]` (first slot), `slot_ptr[1]` (second slot) and `slot_ptr[0]` (third slot). Clear takes priority over a pending step.
- R2: Each accepted key press moves `slot_ptr` one step through the cycle 001 → 100 → 010 → 001. The pointer is always one-hot.
- R3: At a step, the pointer bit that becomes 1 selects the nibble that loads the digit: bit 2 loads `digit_value[11:8]`, bit 1 loads `[7:4]` and bit 0 loads `[3:0]`. The other two nibbles keep their values.
- R4: When several keys are low together, the digit stored is the highest-numbered key among them.
- R5: Key 0 on its own counts as a press and stores the digit 0.
- R6: A key held for longer than the pulse causes exactly one step. No further step occurs until all keys have been high for at least one synchronized cycle.
- R7: After a press is detected, `slot_ptr` and `digit_value` stay unchanged for the whole pulse of `PULSE_CYCLES` cycles. They change together on one edge after the pulse ends.
- R8: The digit is captured when the press is detected, so a key released before the pulse ends is still stored.
- R9: After a clear, entering 3, then 0, then 9 leaves `digit_value` = 12'h309 and `slot_ptr` = 3'b001.
- R10: After reset, `digit_value` is 0 and `slot_ptr` is 3'b001.
- R11: A clear while a pulse is running cancels that pulse, so no step follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| key_n | input | 10 | Key lines, active low; bit k is key k |
| clear_n | input | 1 | Clear key, active low |
| digit_value | output | 12 | Stored packed BCD; first digit in [11:8] |
| slot_ptr | output | 3 | One-hot pointer to the slot last loaded |

## Verification
The bench presses several keys at the same time, including 9 together with 0. A design with an inverted priority or a missing key-0 path would store the wrong digit or fail to take a step. It holds a key much longer than the pulse: a design that re-arms while the key is still down would take extra steps, which show up as unexpected changes with nothing queued. It releases a key before the pulse ends, which exposes a design that samples the digit late and stores 0. It also asserts clear in the middle of a pulse, where a design that does not cancel the timer would take a step after the clear. The 3-0-9 sequence checks that the nibbles are routed in order from the most significant digit down.

// File: rtl/dentry_pkg.sv
package dentry_pkg;

    localparam int NUM_KEYS = 10;
    localparam int DIGIT_W  = 4;
    localparam int SLOTS    = 3;
    localparam int VALUE_W  = DIGIT_W * SLOTS;

    typedef logic [DIGIT_W-1:0]  bcd_t;
    typedef logic [SLOTS-1:0]    slot_t;
    typedef logic [NUM_KEYS-1:0] keys_t;

    localparam slot_t SLOT_HOME = 3'b001;

    typedef struct packed {
        logic active;
        bcd_t digit;
    } key_evt_t;

    // Inverted BCD of the highest-numbered pressed key among 1..9; all ones if none.
    function automatic bcd_t encode_inv(input keys_t key_n);
        bcd_t r;
        r = '1;
        for (int k = 1; k < NUM_KEYS; k++) begin
            if (!key_n[k]) r = ~bcd_t'(k);
        end
        return r;
    endfunction

    // One step of the slot ring: 001 -> 100 -> 010 -> 001.
    function automatic slot_t ring_next(input slot_t p);
        return {p[0], p[2], p[1]};
    endfunction

endpackage

// File: rtl/key_sync.sv
module key_sync #(
    parameter int          WIDTH     = 1,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] IDLE_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= IDLE_VAL;
                else     stage_q[s] <= (s == 0) ? d_in : stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/key_prio_encoder.sv
module key_prio_encoder
    import dentry_pkg::*;
(
    input  keys_t    key_n,
    output key_evt_t evt
);
    bcd_t inv_code;

    always_comb begin
        inv_code   = encode_inv(key_n);
        evt.digit  = ~inv_code;
        evt.active = ~&key_n;
    end

    // R4: key 9 dominates every other key
    always_comb begin
        if (key_n[9] === 1'b0)
            p_top_key_wins_r4: assert (evt.digit == 4'd9 && evt.active);
    end
endmodule

// File: rtl/press_pulse_timer.sv
module press_pulse_timer
    import dentry_pkg::*;
#(
    parameter int PULSE_CYCLES = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  key_evt_t evt,
    output logic     done,
    output bcd_t     digit_q
);
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

    logic             busy;
    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic             start;

    assign start = armed && evt.active && !busy;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            busy    <= 1'b0;
            armed   <= 1'b0;
            cnt     <= '0;
            done    <= 1'b0;
            digit_q <= '0;
        end else begin
            done <= 1'b0;
            if (!evt.active) armed <= 1'b1;
            if (start) begin
                busy    <= 1'b1;
                armed   <= 1'b0;
                cnt     <= CNT_W'(PULSE_CYCLES - 1);
                digit_q <= evt.digit;
            end else if (busy) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R6: the end-of-pulse strobe lasts a single cycle
    p_single_done_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R6: a new pulse never starts while a key is still held from the last one
    p_rearm_needed_r6: assert property (@(posedge clk) disable iff (rst || clear)
        start |=> !armed);
    // R8: the captured digit is stable while the pulse runs
    p_digit_held_r8: assert property (@(posedge clk) disable iff (rst || clear)
        (busy && !start) |=> $stable(digit_q));
endmodule

// File: rtl/slot_ring.sv
module slot_ring
    import dentry_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               advance,
    input  bcd_t               digit,
    output slot_t              ptr,
    output logic [VALUE_W-1:0] value
);
    slot_t ptr_nxt;

    assign ptr_nxt = ring_next(ptr);

    always_ff @(posedge clk) begin
        if (rst || clear)  ptr <= SLOT_HOME;
        else if (advance)  ptr <= ptr_nxt;
    end

    generate
        for (genvar k = 0; k < SLOTS; k++) begin : g_nib
            always_ff @(posedge clk) begin
                if (rst || clear)
                    value[k*DIGIT_W +: DIGIT_W] <= '0;
                else if (advance && ptr_nxt[k] && !ptr[k])
                    value[k*DIGIT_W +: DIGIT_W] <= digit;
            end
        end
    endgenerate

    // R2: the pointer stays one-hot
    p_ptr_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot(ptr));
    // R1: clear returns to home with an empty register
    p_clear_home_r1: assert property (@(posedge clk) disable iff (rst)
        clear |=> (ptr == SLOT_HOME && value == '0));
    // R2: one step per advance
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (advance && !clear) |=> ptr == ring_next($past(ptr)));
    // R7: nothing moves without an advance
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!advance && !clear) |=> ($stable(value) && $stable(ptr)));
endmodule

// File: rtl/digit_entry_reg.sv
module digit_entry_reg
    import dentry_pkg::*;
#(
    parameter int PULSE_CYCLES = 5_000_000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [9:0]          key_n,
    input  logic                clear_n,
    output logic [11:0]         digit_value,
    output logic [2:0]          slot_ptr
);
    keys_t    keys_s;
    logic     clear_s_n;
    key_evt_t evt;
    logic     step;
    bcd_t     digit_q;

    key_sync #(.WIDTH(NUM_KEYS), .STAGES(SYNC_STAGES), .IDLE_VAL('1)) u_key_sync (
        .clk(clk), .rst(rst), .d_in(key_n), .d_out(keys_s)
    );

    key_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_clr_sync (
        .clk(clk), .rst(rst), .d_in(clear_n), .d_out(clear_s_n)
    );

    key_prio_encoder u_enc (
        .key_n(keys_s), .evt(evt)
    );

    press_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .clear(!clear_s_n), .evt(evt),
        .done(step), .digit_q(digit_q)
    );

    slot_ring u_ring (
        .clk(clk), .rst(rst), .clear(!clear_s_n), .advance(step),
        .digit(digit_q), .ptr(slot_ptr), .value(digit_value)
    );
endmodule

// File: tb/digit_entry_reg_tb_top.sv
module digit_entry_reg_tb_top;
    localparam int PULSE = 8;
    localparam int SETTLE = PULSE + 12;

    typedef struct {
        logic [2:0]  ptr;
        logic [11:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  key_n = '1;
    logic        clear_n = 1'b1;
    logic [11:0] digit_value;
    logic [2:0]  slot_ptr;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];
    logic [2:0]  m_ptr = 3'b001;
    logic [11:0] m_val = '0;
    bit mon_on = 0;

    always #2 clk = ~clk;

    digit_entry_reg #(.PULSE_CYCLES(PULSE)) dut_i (
        .clk(clk), .rst(rst), .key_n(key_n), .clear_n(clear_n),
        .digit_value(digit_value), .slot_ptr(slot_ptr)
    );

    task automatic check(input bit ok, input string tag, input logic [14:0] act, input logic [14:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual ptr=%b val=%h expected ptr=%b val=%h",
                     tag, act[14:12], act[11:0], exp[14:12], exp[11:0]);
        end
    endtask

    // Monitor: every output change must match the head of the queue.
    logic [2:0]  prev_ptr;
    logic [11:0] prev_val;
    always @(negedge clk) begin
        if (mon_on && (slot_ptr !== prev_ptr || digit_value !== prev_val)) begin
            if (q.size() == 0) begin
                check(0, "R6 unexpected change", {slot_ptr, digit_value}, {prev_ptr, prev_val});
            end else begin
                exp_t e;
                e = q.pop_front();
                check(slot_ptr == e.ptr && digit_value == e.val, e.tag,
                      {slot_ptr, digit_value}, {e.ptr, e.val});
            end
        end
        prev_ptr = slot_ptr;
        prev_val = digit_value;
    end

    function automatic logic [2:0] rot(input logic [2:0] p);
        return {p[0], p[2], p[1]};
    endfunction

    // Driver: press a key set, hold, release; push expected result.
    task automatic press(input logic [9:0] mask, input int hold, input int digit, input string tag);
        exp_t e;
        m_ptr = rot(m_ptr);
        for (int k = 0; k < 3; k++)
            if (m_ptr[k]) m_val[k*4 +: 4] = 4'(digit);
        e.ptr = m_ptr; e.val = m_val; e.tag = tag;
        q.push_back(e);
        @(negedge clk) key_n = ~mask;
        repeat (hold) @(negedge clk);
        key_n = '1;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic do_clear(input string tag);
        exp_t e;
        if (m_ptr != 3'b001 || m_val != 0) begin
            e.ptr = 3'b001; e.val = '0; e.tag = tag;
            q.push_back(e);
        end
        m_ptr = 3'b001; m_val = '0;
        @(negedge clk) clear_n = 1'b0;
        repeat (3) @(negedge clk);
        clear_n = 1'b1;
        repeat (6) @(negedge clk);
        check(slot_ptr == 3'b001 && digit_value == 0, tag, {slot_ptr, digit_value}, 15'h1000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(slot_ptr == 3'b001 && digit_value == 0, "R10 reset", {slot_ptr, digit_value}, 15'h1000);
        prev_ptr = slot_ptr; prev_val = digit_value;
        mon_on = 1;

        // R9 sequence 3,0,9 with R2/R3/R5 along the way
        press(10'b00_0000_1000, 4, 3, "R3 first digit to [11:8]");
        press(10'b00_0000_0001, 4, 0, "R5 key zero steps");
        press(10'b10_0000_0000, 4, 9, "R2 ring back home");
        check(digit_value == 12'h309 && slot_ptr == 3'b001, "R9 309 entry",
              {slot_ptr, digit_value}, {3'b001, 12'h309});

        do_clear("R1 clear");

        // R4 simultaneous keys 2,7,5
        press(10'b00_1010_0100, 4, 7, "R4 highest key wins");
        // R6 long hold gives one step
        press(10'b00_0001_0000, 4 * PULSE + 20, 4, "R6 held key single step");
        check(q.size() == 0, "R6 no extra step", {slot_ptr, digit_value}, {m_ptr, m_val});
        // R8 short press released before pulse end
        press(10'b01_0000_0000, 3, 8, "R8 early release keeps digit");

        // R7 nothing changes mid-pulse, then R3 other nibbles unchanged
        begin
            exp_t e;
            logic [2:0] p0; logic [11:0] v0;
            p0 = m_ptr; v0 = m_val;
            m_ptr = rot(m_ptr);
            m_val[11:8] = 4'd1;
            e.ptr = m_ptr; e.val = m_val; e.tag = "R3 others kept";
            q.push_back(e);
            @(negedge clk) key_n = ~10'b00_0000_0010;
            repeat (6) @(negedge clk);
            check(slot_ptr == p0 && digit_value == v0, "R7 stable during pulse",
                  {slot_ptr, digit_value}, {p0, v0});
            key_n = '1;
            repeat (SETTLE) @(negedge clk);
            check(digit_value == 12'h148, "R3 value 148", {slot_ptr, digit_value}, {3'b100, 12'h148});
        end

        // R11 clear during pulse cancels the step
        begin
            exp_t e;
            m_ptr = 3'b001; m_val = '0;
            e.ptr = 3'b001; e.val = '0; e.tag = "R11 clear mid pulse";
            q.push_back(e);
            @(negedge clk) key_n = ~10'b00_0100_0000;
            repeat (5) @(negedge clk);
            clear_n = 1'b0; key_n = '1;
            repeat (3) @(negedge clk);
            clear_n = 1'b1;
            repeat (SETTLE + 10) @(negedge clk);
            check(slot_ptr == 3'b001 && digit_value == 0, "R11 no step after clear",
                  {slot_ptr, digit_value}, 15'h1000);
        end

        // R4 9 with 0
        press(10'b10_0000_0001, 4, 9, "R4 nine over zero");
        check(q.size() == 0, "R6 queue drained", {slot_ptr, digit_value}, {m_ptr, m_val});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule